// File: doc/BRIEF.md
# Linked-List Channel Transfer Engine

This block is a bus-mastering I/O channel. Software builds a chain of three-word command descriptors in memory, hands the engine the address of the first one and pulses a go strobe. From then on the engine runs without processor help. It holds its own channel program counter, which points at the current descriptor. For each descriptor it fetches the three words and then moves the block, one byte at a time, between memory and a byte-stream device port in the direction that the descriptor names. After the block it follows the descriptor's link word to the next descriptor.

The direction is chosen per descriptor and the byte order continues across descriptors. This gives scatter: a single stream arriving from the device is spread over several separate buffers. It also gives gather: several buffers are sent out as one device stream. A per-descriptor flag marks the final byte of a physical device block on the outbound stream.

The engine shares the memory bus with the processor, so it raises a request and waits for a grant before every memory access. It interrupts only once per chain: either when it reaches a null link, or when it stops on a malformed descriptor.

Top module: `chan_engine`

## Requirements
- R1: After reset, busy, done, err, irq, bus_req, tx_valid and rx_ready are all 0, err_code is 0 and chan_pc is 0.
- R2: A descriptor occupies three little-endian 32-bit words at chan_pc, chan_pc+4 and chan_pc+8, each fetched as a word read (mem_word=1). The words are:
  - Word 0: bit 0 is the direction (1 = device to memory, 0 = memory to device), bit 1 is the end-of-block flag and bits 31:16 are the byte count.
  - Word 1: the buffer address.
  - Word 2: the link to the next descriptor.
- R3: For a memory-to-device descriptor, bytes are read with byte reads (mem_word=0, data in mem_rdata[7:0]) from ascending addresses starting at the buffer address. They appear on tx_data in that order, one byte per tx_valid/tx_ready handshake, and exactly count bytes are sent.
- R4: For a device-to-memory descriptor, each byte accepted on an rx_valid/rx_ready handshake is written with a byte write to the next ascending address from the buffer address. Exactly count bytes are written, and nothing is written beyond the buffer.
- R5: After a block the engine follows the link word. A link of 0 ends the chain. The byte streams continue in descriptor order across the chain (gather on tx, scatter on rx).
- R6: tx_last is 1 exactly with the final byte of a memory-to-device descriptor whose end-of-block flag is set, and 0 for every other transmitted byte.
- R7: A memory access takes place only on a clock edge where bus_req and bus_gnt are both 1. While the request waits for a grant, bus_req stays 1 and mem_addr does not change. Only device-to-memory bytes are written.
- R8: A chain that ends normally raises irq for exactly one cycle. It then leaves done=1, busy=0 and err=0, with chan_pc holding the address of the last descriptor. Starting a new chain clears done and err.
- R9: A descriptor with count 0 stops the chain with err=1 and err_code=1. No byte moves for that descriptor, chan_pc holds its address and irq pulses once.
- R10: A start pointer or link whose two low bits are not 0 stops the chain with err=1 and err_code=2 and a single irq pulse. A bad start makes no memory access. A bad link leaves chan_pc on the descriptor that held it.
- R11: A start strobe while busy=1 is ignored; the running chain completes unchanged.
- R12: Once tx_valid is 1 it stays 1, with tx_data unchanged, until tx_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Go strobe, one cycle |
| start_ptr | input | AW | Address of the first descriptor |
| busy | output | 1 | Chain in progress |
| done | output | 1 | Last chain ended at a null link |
| err | output | 1 | Last chain stopped on an error |
| err_code | output | 2 | 0 none, 1 zero count, 2 misaligned pointer |
| irq | output | 1 | One-cycle interrupt at chain end or error |
| chan_pc | output | AW | Channel program counter (current descriptor) |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| mem_addr | output | AW | Memory address |
| mem_word | output | 1 | 1 = 32-bit word read, 0 = byte access |
| mem_we | output | 1 | Byte write |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 32 | Read data, same cycle, byte in bits 7:0 |
| tx_valid | output | 1 | Outbound byte valid |
| tx_ready | input | 1 | Device accepts the outbound byte |
| tx_data | output | 8 | Outbound byte |
| tx_last | output | 1 | Final byte of a device block |
| rx_valid | input | 1 | Inbound byte valid |
| rx_ready | output | 1 | Engine accepts the inbound byte |
| rx_data | input | 8 | Inbound byte |

## Verification
The bench builds random chains that mix directions and vary count, buffer offset, grant rate and device readiness. It compares the outbound stream, the tx_last marks and the scattered buffers against a model of the chain.

Directed runs target specific failure modes:
- A single-byte block checks the count-of-one boundary. A design that tested for zero after decrementing would send one byte too many or drop tx_last.
- A zero-count descriptor placed mid-chain catches an engine that wraps the count and streams 65535 bytes.
- A misaligned start and a misaligned link catch an engine that fetches garbage instead of stopping.
- A start strobe during a slow, grant-starved run catches an engine that restarts or reports a spurious error.

// File: rtl/chan_pkg.sv
`timescale 1ns/1ps
package chan_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned CNT_W      = 16;
    localparam int unsigned DIR_BIT    = 0;
    localparam int unsigned EOB_BIT    = 1;
    localparam int unsigned CNT_LSB    = 16;
    localparam int unsigned DESC_WORDS = 3;
    localparam int unsigned ALIGN_BITS = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CHECK,
        S_MRD,
        S_TX,
        S_RX,
        S_MWR,
        S_NEXT
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_ZERO_CNT = 2'd1,
        ERR_MISALIGN = 2'd2
    } chan_err_e;

    typedef struct packed {
        logic             to_mem;
        logic             eob;
        logic [CNT_W-1:0] count;
    } desc_ctl_t;

    function automatic desc_ctl_t unpack_ctl(input logic [WORD_W-1:0] w);
        desc_ctl_t c;
        c.to_mem = w[DIR_BIT];
        c.eob    = w[EOB_BIT];
        c.count  = w[CNT_LSB +: CNT_W];
        return c;
    endfunction

    function automatic logic [3:0] word_offset(input logic [1:0] idx);
        return {idx, 2'b00};
    endfunction

endpackage

// File: rtl/chan_desc_regs.sv
`timescale 1ns/1ps
module chan_desc_regs
    import chan_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_ctl,
    input  logic              load_buf,
    input  logic              load_next,
    input  logic [WORD_W-1:0] word_in,
    input  logic              step,
    output desc_ctl_t         ctl,
    output logic [AW-1:0]     buf_addr,
    output logic [AW-1:0]     next_ptr,
    output logic              last_byte
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl      <= '0;
            buf_addr <= '0;
            next_ptr <= '0;
        end else begin
            if (load_ctl) begin
                ctl <= unpack_ctl(word_in);
            end else if (step) begin
                ctl.count <= ctl.count - 1'b1;
            end
            if (load_buf) begin
                buf_addr <= word_in[AW-1:0];
            end else if (step) begin
                buf_addr <= buf_addr + 1'b1;
            end
            if (load_next) begin
                next_ptr <= word_in[AW-1:0];
            end
        end
    end

    assign last_byte = (ctl.count == CNT_W'(1));

    // R9: a byte never moves against an exhausted count
    a_r9_step_nonzero: assert property (@(posedge clk) disable iff (rst)
        step |-> (ctl.count != '0));

endmodule

// File: rtl/chan_seq.sv
`timescale 1ns/1ps
module chan_seq
    import chan_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_ptr,
    input  logic          bus_gnt,
    input  logic [7:0]    rd_byte,
    input  logic          tx_ready,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  desc_ctl_t     ctl,
    input  logic          last_byte,
    input  logic [AW-1:0] next_ptr,
    output seq_state_e    state,
    output logic [1:0]    word_idx,
    output logic [AW-1:0] pc,
    output logic          load_ctl,
    output logic          load_buf,
    output logic          load_next,
    output logic          step,
    output logic [7:0]    hold,
    output logic          busy,
    output logic          done,
    output logic          err,
    output chan_err_e     err_code,
    output logic          irq,
    output logic          tx_valid,
    output logic          tx_last,
    output logic          rx_ready,
    output logic          bus_req,
    output logic          mem_we
);

    localparam logic [1:0] LAST_WORD = 2'(DESC_WORDS - 1);

    function automatic logic misaligned(input logic [AW-1:0] p);
        return p[ALIGN_BITS-1:0] != '0;
    endfunction

    logic fetch_hit;

    always_comb begin
        bus_req   = (state == S_FETCH) || (state == S_MRD) || (state == S_MWR);
        mem_we    = (state == S_MWR);
        tx_valid  = (state == S_TX);
        rx_ready  = (state == S_RX);
        tx_last   = tx_valid && ctl.eob && last_byte;
        fetch_hit = (state == S_FETCH) && bus_gnt;
        load_ctl  = fetch_hit && (word_idx == 2'd0);
        load_buf  = fetch_hit && (word_idx == 2'd1);
        load_next = fetch_hit && (word_idx == 2'd2);
        step      = ((state == S_TX) && tx_ready) || ((state == S_MWR) && bus_gnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            word_idx <= '0;
            pc       <= '0;
            hold     <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            err_code <= ERR_NONE;
            irq      <= 1'b0;
        end else begin
            irq <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        done     <= 1'b0;
                        err      <= 1'b0;
                        err_code <= ERR_NONE;
                        if (misaligned(start_ptr)) begin
                            err      <= 1'b1;
                            err_code <= ERR_MISALIGN;
                            irq      <= 1'b1;
                        end else begin
                            pc       <= start_ptr;
                            word_idx <= '0;
                            busy     <= 1'b1;
                            state    <= S_FETCH;
                        end
                    end
                end
                S_FETCH: begin
                    if (bus_gnt) begin
                        if (word_idx == LAST_WORD) begin
                            state <= S_CHECK;
                        end else begin
                            word_idx <= word_idx + 2'd1;
                        end
                    end
                end
                S_CHECK: begin
                    if (ctl.count == '0) begin
                        err      <= 1'b1;
                        err_code <= ERR_ZERO_CNT;
                        busy     <= 1'b0;
                        irq      <= 1'b1;
                        state    <= S_IDLE;
                    end else begin
                        state <= ctl.to_mem ? S_RX : S_MRD;
                    end
                end
                S_MRD: begin
                    if (bus_gnt) begin
                        hold  <= rd_byte;
                        state <= S_TX;
                    end
                end
                S_TX: begin
                    if (tx_ready) begin
                        state <= last_byte ? S_NEXT : S_MRD;
                    end
                end
                S_RX: begin
                    if (rx_valid) begin
                        hold  <= rx_data;
                        state <= S_MWR;
                    end
                end
                S_MWR: begin
                    if (bus_gnt) begin
                        state <= last_byte ? S_NEXT : S_RX;
                    end
                end
                S_NEXT: begin
                    if (next_ptr == '0) begin
                        done  <= 1'b1;
                        busy  <= 1'b0;
                        irq   <= 1'b1;
                        state <= S_IDLE;
                    end else if (misaligned(next_ptr)) begin
                        err      <= 1'b1;
                        err_code <= ERR_MISALIGN;
                        busy     <= 1'b0;
                        irq      <= 1'b1;
                        state    <= S_IDLE;
                    end else begin
                        pc       <= next_ptr;
                        word_idx <= '0;
                        state    <= S_FETCH;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R8: the interrupt is a single-cycle pulse
    a_r8_irq_pulse: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R8: an idle engine drives no bus or device handshake
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!bus_req && !tx_valid && !rx_ready));

    // R8: busy, done and err are mutually exclusive
    a_r8_status_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({busy, done, err}));

    // R12: an offered byte is held until taken
    a_r12_tx_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(hold)));

endmodule

// File: rtl/chan_bus_if.sv
`timescale 1ns/1ps
module chan_bus_if
    import chan_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  seq_state_e    state,
    input  logic [1:0]    word_idx,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] buf_addr,
    input  logic [7:0]    hold,
    output logic [AW-1:0] mem_addr,
    output logic          mem_word,
    output logic [7:0]    mem_wdata
);

    always_comb begin
        mem_word  = (state == S_FETCH);
        mem_addr  = mem_word ? (pc + AW'(word_offset(word_idx))) : buf_addr;
        mem_wdata = hold;
    end

endmodule

// File: rtl/chan_engine.sv
`timescale 1ns/1ps
module chan_engine
    import chan_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_ptr,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [1:0]    err_code,
    output logic          irq,
    output logic [AW-1:0] chan_pc,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [AW-1:0] mem_addr,
    output logic          mem_word,
    output logic          mem_we,
    output logic [7:0]    mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          rx_valid,
    output logic          rx_ready,
    input  logic [7:0]    rx_data
);

    seq_state_e    state;
    logic [1:0]    word_idx;
    logic          load_ctl, load_buf, load_next, step, last_byte;
    logic [7:0]    hold;
    desc_ctl_t     ctl;
    logic [AW-1:0] buf_addr, next_ptr;
    chan_err_e     err_e;

    chan_desc_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .load_ctl  (load_ctl),
        .load_buf  (load_buf),
        .load_next (load_next),
        .word_in   (mem_rdata),
        .step      (step),
        .ctl       (ctl),
        .buf_addr  (buf_addr),
        .next_ptr  (next_ptr),
        .last_byte (last_byte)
    );

    chan_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_ptr (start_ptr),
        .bus_gnt   (bus_gnt),
        .rd_byte   (mem_rdata[7:0]),
        .tx_ready  (tx_ready),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .ctl       (ctl),
        .last_byte (last_byte),
        .next_ptr  (next_ptr),
        .state     (state),
        .word_idx  (word_idx),
        .pc        (chan_pc),
        .load_ctl  (load_ctl),
        .load_buf  (load_buf),
        .load_next (load_next),
        .step      (step),
        .hold      (hold),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .err_code  (err_e),
        .irq       (irq),
        .tx_valid  (tx_valid),
        .tx_last   (tx_last),
        .rx_ready  (rx_ready),
        .bus_req   (bus_req),
        .mem_we    (mem_we)
    );

    chan_bus_if #(.AW(AW)) u_bus (
        .state     (state),
        .word_idx  (word_idx),
        .pc        (chan_pc),
        .buf_addr  (buf_addr),
        .hold      (hold),
        .mem_addr  (mem_addr),
        .mem_word  (mem_word),
        .mem_wdata (mem_wdata)
    );

    assign err_code = err_e;
    assign tx_data  = hold;

    // R7: a pending request keeps its address until granted
    a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt) |=> (bus_req && $stable(mem_addr)));

    // R3: outbound bytes only for memory-to-device descriptors
    a_r3_tx_dir: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !ctl.to_mem);

    // R4: memory writes only for device-to-memory descriptors
    a_r4_wr_dir: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (ctl.to_mem && !mem_word));

endmodule

// File: tb/chan_engine_tb.sv
`timescale 1ns/1ps
module chan_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] start_ptr = '0;
    logic        busy, done, err, irq, bus_req, mem_word, mem_we, tx_valid, tx_last, rx_ready;
    logic [1:0]  err_code;
    logic [31:0] chan_pc, mem_addr, mem_rdata;
    logic [7:0]  mem_wdata, tx_data;
    logic        bus_gnt = 1'b0, tx_ready = 1'b0, rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;

    always #2 clk = ~clk;

    chan_engine #(.AW(32)) u_dut (
        .clk(clk), .rst(rst), .start(start), .start_ptr(start_ptr),
        .busy(busy), .done(done), .err(err), .err_code(err_code), .irq(irq),
        .chan_pc(chan_pc), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_addr(mem_addr), .mem_word(mem_word), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
    );

    // memory model: 4 KiB, combinational read
    logic [7:0]  mem [0:4095];
    logic [11:0] ra;
    assign ra = mem_addr[11:0];
    assign mem_rdata = mem_word ? {mem[ra + 12'd3], mem[ra + 12'd2], mem[ra + 12'd1], mem[ra]}
                                : {24'h0, mem[ra]};

    int checks = 0;
    int fails  = 0;

    int gnt_pct = 100, tx_pct = 100, rx_pct = 100;
    logic [7:0] rx_stream [0:255];
    logic [7:0] tx_log [0:511];
    bit         tx_last_log [0:511];
    int tx_n = 0, rx_idx = 0, wr_cnt = 0, acc_cnt = 0, irq_cnt = 0, hold_viol = 0;

    // bus and device models, acting mid-cycle
    initial begin
        bit         rx_fired = 0;
        bit         tx_pend  = 0;
        logic [7:0] tx_prev  = '0;
        forever begin
            @(negedge clk);
            if (tx_pend && !(tx_valid && tx_data == tx_prev)) hold_viol++;
            if (rx_fired) rx_valid = 1'b0;
            bus_gnt  = ($urandom % 100) < gnt_pct;
            tx_ready = ($urandom % 100) < tx_pct;
            if (!rx_valid) rx_valid = ($urandom % 100) < rx_pct;
            rx_data  = rx_stream[rx_idx[7:0]];
            rx_fired = rx_valid && rx_ready;
            if (rx_fired) rx_idx++;
            if (bus_req && bus_gnt) begin
                acc_cnt++;
                if (mem_we) begin
                    mem[ra] = mem_wdata;
                    wr_cnt++;
                end
            end
            if (tx_valid && tx_ready) begin
                tx_log[tx_n]      = tx_data;
                tx_last_log[tx_n] = tx_last;
                tx_n++;
            end
            tx_pend = tx_valid && !tx_ready;
            tx_prev = tx_data;
            if (irq) irq_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic put_w(input int a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) mem[(a + k) % 4096] = v[8*k +: 8];
    endtask

    task automatic put_desc(input int base, input bit to_mem, input bit eob, input int cnt,
                            input int bufa, input int nxt);
        put_w(base, {cnt[15:0], 14'b0, eob, to_mem});
        put_w(base + 4, bufa);
        put_w(base + 8, nxt);
    endtask

    int irq_delta;

    task automatic run_chain(input logic [31:0] sp, input bit poke);
        int i0;
        @(posedge clk); #1;
        tx_n = 0; rx_idx = 0; wr_cnt = 0; acc_cnt = 0; hold_viol = 0;
        for (int k = 0; k < 256; k++) rx_stream[k] = 8'($urandom);
        i0 = irq_cnt;
        start = 1'b1; start_ptr = sp;
        @(posedge clk); #1;
        start = 1'b0;
        if (poke) begin
            repeat (4) @(posedge clk);
            #1;
            start = 1'b1; start_ptr = 32'h101;
            @(posedge clk); #1;
            start = 1'b0;
        end
        for (int c = 0; c < 20000 && irq_cnt == i0; c++) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
        irq_delta = irq_cnt - i0;
    endtask

    // watchdog
    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog all-requirements actual=hung expected=finished");
        summary();
        $finish;
    end

    int         n, exp_n, in_tot, p;
    bit         d_dir [0:7];
    bit         d_eob [0:7];
    int         d_cnt [0:7];
    int         d_buf [0:7];
    logic [7:0] exp_tx [0:511];
    bit         exp_last [0:511];

    task automatic check_chain(input int last_base);
        chk(tx_n == exp_n, "R3 R5 tx byte count", tx_n, exp_n);
        for (int k = 0; k < exp_n && k < tx_n; k++) begin
            chk(tx_log[k] == exp_tx[k], "R3 R5 gather byte", tx_log[k], exp_tx[k]);
            chk(tx_last_log[k] == exp_last[k], "R6 tx_last", tx_last_log[k], exp_last[k]);
        end
        p = 0;
        for (int i = 0; i < n; i++) begin
            if (d_dir[i]) begin
                for (int k = 0; k < d_cnt[i]; k++) begin
                    chk(mem[d_buf[i] + k] == rx_stream[p], "R4 R5 scatter byte",
                        mem[d_buf[i] + k], rx_stream[p]);
                    p++;
                end
                chk(mem[d_buf[i] + d_cnt[i]] == 8'hEE, "R4 no overrun",
                    mem[d_buf[i] + d_cnt[i]], 8'hEE);
            end
        end
        chk(wr_cnt == in_tot, "R7 write count", wr_cnt, in_tot);
        chk(irq_delta == 1, "R8 single irq", irq_delta, 1);
        chk({busy, done, err} == 3'b010, "R8 status", {busy, done, err}, 3'b010);
        chk(chan_pc == last_base, "R2 R8 chan_pc", chan_pc, last_base);
        chk(hold_viol == 0, "R12 tx hold", hold_viol, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 4096; k++) mem[k] = 8'h00;
        for (int k = 0; k < 256; k++) rx_stream[k] = 8'h00;
        repeat (5) @(posedge clk);
        #1;
        chk({busy, done, err, irq, bus_req, tx_valid, rx_ready} == 7'b0, "R1 reset outputs",
            {busy, done, err, irq, bus_req, tx_valid, rx_ready}, 0);
        chk(err_code == 2'd0 && chan_pc == 0, "R1 reset code/pc", {err_code, chan_pc[7:0]}, 0);
        rst = 1'b0;

        // random chains mixing scatter and gather
        for (int t = 0; t < 24; t++) begin
            gnt_pct = 25 + $urandom % 76;
            tx_pct  = 25 + $urandom % 76;
            rx_pct  = 25 + $urandom % 76;
            n = 1 + $urandom % 5;
            exp_n = 0; in_tot = 0;
            for (int i = 0; i < n; i++) begin
                d_dir[i] = $urandom % 2;
                d_eob[i] = (i == n - 1) || ($urandom % 2);
                d_cnt[i] = 1 + $urandom % 12;
                d_buf[i] = 32'h400 + i * 64 + $urandom % 8;
                put_desc(32'h100 + i * 16, d_dir[i], d_eob[i], d_cnt[i], d_buf[i],
                         (i == n - 1) ? 0 : 32'h100 + (i + 1) * 16);
                if (d_dir[i]) begin
                    for (int k = -1; k <= d_cnt[i]; k++) mem[d_buf[i] + k] = 8'hEE;
                    in_tot += d_cnt[i];
                end else begin
                    for (int k = 0; k < d_cnt[i]; k++) begin
                        mem[d_buf[i] + k] = 8'($urandom);
                        exp_tx[exp_n]   = mem[d_buf[i] + k];
                        exp_last[exp_n] = d_eob[i] && (k == d_cnt[i] - 1);
                        exp_n++;
                    end
                end
            end
            run_chain(32'h100, 1'b0);
            check_chain(32'h100 + (n - 1) * 16);
        end

        // single-byte outbound block with end-of-block flag
        gnt_pct = 50; tx_pct = 50; rx_pct = 50;
        n = 1; exp_n = 1; in_tot = 0;
        d_dir[0] = 0; d_eob[0] = 1; d_cnt[0] = 1; d_buf[0] = 32'h600;
        mem[32'h600] = 8'h5A; exp_tx[0] = 8'h5A; exp_last[0] = 1;
        put_desc(32'h200, 0, 1, 1, 32'h600, 0);
        run_chain(32'h200, 1'b0);
        check_chain(32'h200);

        // zero count in the middle of a chain
        put_desc(32'h100, 0, 0, 3, 32'h400, 32'h110);
        put_desc(32'h110, 0, 1, 0, 32'h440, 0);
        run_chain(32'h100, 1'b0);
        chk(err && err_code == 2'd1, "R9 zero-count error", {err, err_code}, 3'b101);
        chk(!done && !busy, "R9 stopped", {busy, done}, 0);
        chk(chan_pc == 32'h110, "R9 chan_pc", chan_pc, 32'h110);
        chk(tx_n == 3, "R9 bytes before stop", tx_n, 3);
        chk(irq_delta == 1, "R9 single irq", irq_delta, 1);

        // misaligned link
        for (int k = 0; k < 4; k++) mem[32'h500 + k] = 8'hEE;
        put_desc(32'h100, 1, 0, 2, 32'h500, 32'h112);
        run_chain(32'h100, 1'b0);
        chk(err && err_code == 2'd2, "R10 bad link error", {err, err_code}, 3'b110);
        chk(chan_pc == 32'h100, "R10 chan_pc kept", chan_pc, 32'h100);
        chk(wr_cnt == 2, "R10 block done before stop", wr_cnt, 2);
        chk(irq_delta == 1, "R10 single irq", irq_delta, 1);

        // misaligned start
        run_chain(32'h102, 1'b0);
        chk(err && err_code == 2'd2, "R10 bad start error", {err, err_code}, 3'b110);
        chk(acc_cnt == 0, "R10 no access on bad start", acc_cnt, 0);
        chk(irq_delta == 1 && !busy, "R10 bad start irq", irq_delta, 1);

        // start while busy is ignored (also clears the previous error)
        gnt_pct = 15; tx_pct = 40;
        n = 2; exp_n = 0; in_tot = 0;
        for (int i = 0; i < 2; i++) begin
            d_dir[i] = 0; d_eob[i] = (i == 1); d_cnt[i] = 4; d_buf[i] = 32'h700 + i * 32;
            put_desc(32'h180 + i * 16, 0, d_eob[i], 4, d_buf[i], (i == 1) ? 0 : 32'h190);
            for (int k = 0; k < 4; k++) begin
                mem[d_buf[i] + k] = 8'($urandom);
                exp_tx[exp_n] = mem[d_buf[i] + k];
                exp_last[exp_n] = d_eob[i] && (k == 3);
                exp_n++;
            end
        end
        run_chain(32'h180, 1'b1);
        chk(err == 0, "R11 start while busy ignored", err, 0);
        check_chain(32'h190);

        summary();
        $finish;
    end

endmodule